// File: doc/BRIEF.md
# Interval Timer Bus Register Block

This block sits between an 8-bit register bus and three 16-bit timer channels whose counting logic lives elsewhere. It decodes five addresses: three channel data ports (0, 1, 2), a control port (3) and a system-control port (4). Control words program a channel's mode, BCD flag and access mode. They can also freeze a channel's count, or, through the read-back form, freeze the count and/or the status of any group of channels. Each channel keeps its own byte-order state, so a 16-bit count moves over the 8-bit bus one byte at a time, low byte first.

The counters are reached through a plain per-channel interface. A one-cycle load strobe carries a new count, mode and BCD flag. A live count and an output level come back from each channel. The system-control port sets channel 2's gate and reports that gate together with channel 2's output.

Requests use valid/ready and read responses use valid/ready. A read is accepted on a cycle where `req_valid` and `req_ready` are both high, and its data appears with `rsp_valid` on the next cycle. While a response waits for `rsp_ready`, `req_ready` stays low and the response data is held, so a stalled consumer stalls the bus. Writes produce no response.

Top module: `tmr_bus_regs`

## Requirements
- R1: A read of the control port (address 3) returns 0xFF. A read of addresses 5 to 7 returns 0x00, and writes to those addresses change nothing.
- R2: A control word whose bits 7:6 name channel 0, 1 or 2 and whose bits 5:4 are nonzero does the following for that channel: it stores bits 5:4 as the access mode (01 low only, 10 high only, 11 low then high), bits 3:1 as the mode and bit 0 as the BCD flag; it sets null-count; it arms the write and read byte sequence for that access mode; and it clears the staged count.
- R3: In access mode 11, the first data write fills the low byte and the second fills the high byte. In the cycle after the second write, that channel's load strobe pulses for one cycle with the count, mode and BCD flag, and null-count clears.
- R4: In access modes 01 and 10, a single data write completes the load, and the byte that was not written loads as zero.
- R5: A data read returns the armed bytes in order, low byte before high byte. Each byte is taken from the live count at the cycle the read is accepted, unless a count is latched. A read with no bytes left returns 0x00.
- R6: A control word with bits 5:4 = 00 latches the named channel's live count and re-arms its read sequence. It is ignored while an earlier latched count is unread. The latch is released when the last armed byte has been read.
- R7: A control word with bits 7:6 = 11 is a read-back command. Bit 1, 2 and 3 select channels 0, 1 and 2. Bit 5 low latches the count of each selected channel, by the same rules as R6.
- R8: Bit 4 low in a read-back command latches the status byte of each selected channel, unless a status is already latched. The status byte holds the output level in bit 7, null-count in bit 6, the access mode in bits 5:4, the mode in bits 3:1 and BCD in bit 0. The next data read returns the status byte and clears it, ahead of any latched count.
- R9: Completing a load discards any latched count and latched status of that channel.
- R10: A data write to a channel with no armed write bytes is ignored and produces no load strobe.
- R11: A write to the system-control port sets channel 2's gate from bit 0. A read of that port returns the gate in bit 0, channel 2's output in bit 5, and zeros in the other bits.
- R12: `req_ready` is high exactly when no read response is pending. A pending response keeps `rsp_valid` high and `rsp_rdata` stable until `rsp_ready` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Bus request present |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | 3 | Register address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read data present |
| rsp_ready | input | 1 | Consumer takes read data |
| rsp_rdata | output | 8 | Read data |
| ch_count | input | 48 | Live count of each channel, 16 bits per channel, channel 0 in the low bits |
| ch_out | input | 3 | Output level of each channel |
| ch_load | output | 3 | One-cycle load strobe per channel |
| ch_load_count | output | 48 | Count handed over with the strobe |
| ch_load_mode | output | 9 | Mode handed over, 3 bits per channel |
| ch_load_bcd | output | 3 | BCD flag handed over |
| gate2 | output | 1 | Gate of channel 2 |

## Verification
Directed sequences cover these cases: a status read-back right after programming, where null-count must show; a two-byte load split across writes; a frozen count read while the live count keeps changing, with a second latch attempt in between; a read-back count latch on a channel group; a load that must discard a latch; a single-byte load, where the other byte must load as zero; and a stalled response consumer. Random streams then mix programming, latch, read-back, data and system-control traffic, with live counts and output levels changing before every request. These streams separate errors in byte order, in latch priority and in release timing from errors in address decode.

// File: rtl/tmr_bus_pkg.sv
package tmr_bus_pkg;
  localparam int NCH    = 3;
  localparam int CNT_W  = 16;
  localparam int BYTE_W = 8;
  localparam int MODE_W = 3;
  localparam int ADR_W  = 3;
  localparam logic [ADR_W-1:0] A_CTL = 3'd3;
  localparam logic [ADR_W-1:0] A_SYS = 3'd4;
  localparam logic [1:0] SEL_READBACK = 2'b11;
  localparam logic [1:0] ACC_LATCH    = 2'b00;
endpackage

// File: rtl/tmr_cmd_decode.sv
module tmr_cmd_decode import tmr_bus_pkg::*; (
  input  logic              acc,
  input  logic              wr,
  input  logic [ADR_W-1:0]  addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [NCH-1:0]    prog,
  output logic [NCH-1:0]    cnt_lat,
  output logic [NCH-1:0]    sts_lat,
  output logic [NCH-1:0]    dwr,
  output logic [NCH-1:0]    drd,
  output logic              sys_wr
);
  logic ctl;
  logic [NCH-1:0] rb_hit;
  logic [NCH-1:0] direct;

  assign ctl    = acc & wr & (addr == A_CTL);
  assign sys_wr = acc & wr & (addr == A_SYS);

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    localparam logic [ADR_W-1:0] GA = ADR_W'(g);
    assign dwr[g]     = acc & wr & (addr == GA);
    assign drd[g]     = acc & ~wr & (addr == GA);
    // read-back: select bit g+1, request bits are active low
    assign rb_hit[g]  = ctl & (wdata[7:6] == SEL_READBACK) & wdata[g+1];
    assign direct[g]  = ctl & (wdata[7:6] == 2'(g));
    assign cnt_lat[g] = (rb_hit[g] & ~wdata[5]) | (direct[g] & (wdata[5:4] == ACC_LATCH));
    assign sts_lat[g] = rb_hit[g] & ~wdata[4];
    assign prog[g]    = direct[g] & (wdata[5:4] != ACC_LATCH);
  end
endmodule

// File: rtl/tmr_chan_regs.sv
module tmr_chan_regs import tmr_bus_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog,
  input  logic              cnt_latch,
  input  logic              sts_latch,
  input  logic              data_wr,
  input  logic              data_rd,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [CNT_W-1:0]  live_count,
  input  logic              live_out,
  output logic [BYTE_W-1:0] rd_byte,
  output logic              load,
  output logic [CNT_W-1:0]  load_count,
  output logic [MODE_W-1:0] load_mode,
  output logic              load_bcd
);
  logic [1:0]        rw;
  logic [MODE_W-1:0] mode;
  logic              bcd;
  logic              null_f;
  logic              wr_lo, wr_hi, rd_lo, rd_hi;
  logic              cnt_held, sts_held;
  logic [CNT_W-1:0]  held_cnt;
  logic [BYTE_W-1:0] held_sts;
  logic [CNT_W-1:0]  stage;
  logic [CNT_W-1:0]  stage_nx;
  logic [CNT_W-1:0]  rd_src;
  logic [BYTE_W-1:0] status_now;
  logic              last_byte;

  assign rd_src     = cnt_held ? held_cnt : live_count;
  assign status_now = {live_out, null_f, rw, mode, bcd};
  assign stage_nx   = wr_lo ? {stage[CNT_W-1:BYTE_W], wdata} : {wdata, stage[BYTE_W-1:0]};
  assign last_byte  = wr_lo ^ wr_hi;

  always_comb begin
    if (sts_held)   rd_byte = held_sts;
    else if (rd_lo) rd_byte = rd_src[BYTE_W-1:0];
    else if (rd_hi) rd_byte = rd_src[CNT_W-1:BYTE_W];
    else            rd_byte = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rw <= '0; mode <= '0; bcd <= 1'b0; null_f <= 1'b0;
      wr_lo <= 1'b0; wr_hi <= 1'b0; rd_lo <= 1'b0; rd_hi <= 1'b0;
      cnt_held <= 1'b0; sts_held <= 1'b0;
      held_cnt <= '0; held_sts <= '0; stage <= '0;
      load <= 1'b0; load_count <= '0; load_mode <= '0; load_bcd <= 1'b0;
    end else begin
      load <= 1'b0;
      if (prog) begin
        rw     <= wdata[5:4];
        mode   <= wdata[3:1];
        bcd    <= wdata[0];
        null_f <= 1'b1;
        wr_lo  <= wdata[4];
        wr_hi  <= wdata[5];
        rd_lo  <= wdata[4];
        rd_hi  <= wdata[5];
        stage  <= '0;
      end else if (data_wr && (wr_lo || wr_hi)) begin
        stage <= stage_nx;
        if (wr_lo) wr_lo <= 1'b0;
        else       wr_hi <= 1'b0;
        if (last_byte) begin
          load       <= 1'b1;
          load_count <= stage_nx;
          load_mode  <= mode;
          load_bcd   <= bcd;
          null_f     <= 1'b0;
          cnt_held   <= 1'b0;
          sts_held   <= 1'b0;
        end
      end else if (data_rd) begin
        if (sts_held) begin
          sts_held <= 1'b0;
        end else if (rd_lo || rd_hi) begin
          if (rd_lo) rd_lo <= 1'b0;
          else       rd_hi <= 1'b0;
          if (rd_lo ^ rd_hi) cnt_held <= 1'b0;
        end
      end else begin
        if (cnt_latch && !cnt_held) begin
          cnt_held <= 1'b1;
          held_cnt <= live_count;
          rd_lo    <= rw[0];
          rd_hi    <= rw[1];
        end
        if (sts_latch && !sts_held) begin
          sts_held <= 1'b1;
          held_sts <= status_now;
        end
      end
    end
  end
endmodule

// File: rtl/tmr_read_port.sv
module tmr_read_port import tmr_bus_pkg::*; (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  acc,
  input  logic                  wr,
  input  logic [ADR_W-1:0]      addr,
  input  logic [NCH*BYTE_W-1:0] chan_bytes,
  input  logic [BYTE_W-1:0]     sys_byte,
  input  logic                  rsp_ready,
  output logic                  req_ready,
  output logic                  rsp_valid,
  output logic [BYTE_W-1:0]     rsp_data
);
  logic [BYTE_W-1:0] rd_mux;

  assign req_ready = ~rsp_valid;

  always_comb begin
    rd_mux = '0;
    if (addr == A_CTL)      rd_mux = '1;
    else if (addr == A_SYS) rd_mux = sys_byte;
    for (int i = 0; i < NCH; i++)
      if (addr == ADR_W'(i)) rd_mux = chan_bytes[i*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      if (rsp_valid && rsp_ready) rsp_valid <= 1'b0;
      if (acc && !wr) begin
        rsp_valid <= 1'b1;
        rsp_data  <= rd_mux;
      end
    end
  end
endmodule

// File: rtl/tmr_bus_regs.sv
module tmr_bus_regs import tmr_bus_pkg::*; (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_write,
  input  logic [ADR_W-1:0]      req_addr,
  input  logic [BYTE_W-1:0]     req_wdata,
  output logic                  rsp_valid,
  input  logic                  rsp_ready,
  output logic [BYTE_W-1:0]     rsp_rdata,
  input  logic [NCH*CNT_W-1:0]  ch_count,
  input  logic [NCH-1:0]        ch_out,
  output logic [NCH-1:0]        ch_load,
  output logic [NCH*CNT_W-1:0]  ch_load_count,
  output logic [NCH*MODE_W-1:0] ch_load_mode,
  output logic [NCH-1:0]        ch_load_bcd,
  output logic                  gate2
);
  logic acc;
  logic [NCH-1:0] prog, cnt_lat, sts_lat, dwr, drd;
  logic sys_wr;
  logic [NCH*BYTE_W-1:0] chan_bytes;
  logic [BYTE_W-1:0] sys_byte;

  assign acc = req_valid & req_ready;

  tmr_cmd_decode u_dec (
    .acc(acc), .wr(req_write), .addr(req_addr), .wdata(req_wdata),
    .prog(prog), .cnt_lat(cnt_lat), .sts_lat(sts_lat),
    .dwr(dwr), .drd(drd), .sys_wr(sys_wr)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    tmr_chan_regs u_chan (
      .clk(clk), .rst_n(rst_n),
      .prog(prog[g]), .cnt_latch(cnt_lat[g]), .sts_latch(sts_lat[g]),
      .data_wr(dwr[g]), .data_rd(drd[g]), .wdata(req_wdata),
      .live_count(ch_count[g*CNT_W +: CNT_W]), .live_out(ch_out[g]),
      .rd_byte(chan_bytes[g*BYTE_W +: BYTE_W]),
      .load(ch_load[g]),
      .load_count(ch_load_count[g*CNT_W +: CNT_W]),
      .load_mode(ch_load_mode[g*MODE_W +: MODE_W]),
      .load_bcd(ch_load_bcd[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      gate2 <= 1'b0;
    else if (sys_wr) gate2 <= req_wdata[0];
  end

  always_comb begin
    sys_byte = '0;
    sys_byte[0] = gate2;
    sys_byte[5] = ch_out[2];
  end

  tmr_read_port u_rd (
    .clk(clk), .rst_n(rst_n), .acc(acc), .wr(req_write), .addr(req_addr),
    .chan_bytes(chan_bytes), .sys_byte(sys_byte), .rsp_ready(rsp_ready),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_rdata)
  );
endmodule

// File: rtl/tmr_bus_regs_chk.sv
module tmr_bus_regs_chk import tmr_bus_pkg::*; (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [ADR_W-1:0]  req_addr,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [BYTE_W-1:0] rsp_rdata,
  input logic [NCH-1:0]    ch_load,
  input logic              gate2
);
  logic acc;
  assign acc = req_valid & req_ready;

  assert_ctl_read_ff_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !req_write && req_addr == A_CTL) |=> (rsp_valid && rsp_rdata == 8'hFF));

  assert_load_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_load));

  assert_load_from_data_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|ch_load) |-> $past(acc && req_write && req_addr < ADR_W'(NCH)));

  assert_gate_from_sys_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (gate2 != $past(gate2)) |-> $past(acc && req_write && req_addr == A_SYS));

  assert_rsp_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  assert_ready_blocked_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);
endmodule

bind tmr_bus_regs tmr_bus_regs_chk chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_addr(req_addr), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .ch_load(ch_load), .gate2(gate2)
);

// File: tb/tmr_bus_regs_tb_top.sv
module tmr_bus_regs_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [2:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic req_ready, rsp_valid;
  logic [7:0] rsp_rdata;
  logic [47:0] ch_count = '0;
  logic [2:0] ch_out = '0;
  logic [2:0] ch_load, ch_load_bcd;
  logic [47:0] ch_load_count;
  logic [8:0] ch_load_mode;
  logic gate2;

  int n_cmp = 0, n_bad = 0;
  string tag_ovr = "";

  always #10 clk = ~clk;

  tmr_bus_regs dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .ch_count(ch_count), .ch_out(ch_out), .ch_load(ch_load),
    .ch_load_count(ch_load_count), .ch_load_mode(ch_load_mode),
    .ch_load_bcd(ch_load_bcd), .gate2(gate2)
  );

  // bench model state
  logic [1:0]  m_rw[3];
  logic [2:0]  m_mode[3];
  logic        m_bcd[3], m_null[3];
  logic        m_wlo[3], m_whi[3], m_rlo[3], m_rhi[3];
  logic        m_cl[3], m_sl[3];
  logic [15:0] m_cv[3], m_stage[3];
  logic [7:0]  m_sv[3];
  logic        m_gate;
  logic [2:0]  e_load;
  logic [15:0] e_cnt[3];
  logic [2:0]  e_mode[3];
  logic        e_bcd[3];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic string pick(string dflt);
    return (tag_ovr != "") ? tag_ovr : dflt;
  endfunction

  task automatic m_reset();
    for (int i = 0; i < 3; i++) begin
      m_rw[i] = 0; m_mode[i] = 0; m_bcd[i] = 0; m_null[i] = 0;
      m_wlo[i] = 0; m_whi[i] = 0; m_rlo[i] = 0; m_rhi[i] = 0;
      m_cl[i] = 0; m_sl[i] = 0; m_cv[i] = 0; m_stage[i] = 0; m_sv[i] = 0;
    end
    m_gate = 0;
  endtask

  function automatic logic [15:0] live(int i);
    return ch_count[i*16 +: 16];
  endfunction

  task automatic m_latch_cnt(int i);
    if (!m_cl[i]) begin
      m_cl[i] = 1; m_cv[i] = live(i);
      m_rlo[i] = m_rw[i][0]; m_rhi[i] = m_rw[i][1];
    end
  endtask

  // model of a write; sets e_load and load values, returns a tag
  task automatic m_write(logic [2:0] a, logic [7:0] d, output string tag);
    e_load = '0;
    tag = "R3";
    if (a == 3'd3) begin
      if (d[7:6] == 2'b11) begin
        for (int i = 0; i < 3; i++) if (d[i+1]) begin
          if (!d[4] && !m_sl[i]) begin
            m_sl[i] = 1;
            m_sv[i] = {ch_out[i], m_null[i], m_rw[i], m_mode[i], m_bcd[i]};
          end
          if (!d[5]) m_latch_cnt(i);
        end
      end else if (d[5:4] == 2'b00) begin
        m_latch_cnt(int'(d[7:6]));
      end else begin
        int c = int'(d[7:6]);
        m_rw[c] = d[5:4]; m_mode[c] = d[3:1]; m_bcd[c] = d[0]; m_null[c] = 1;
        m_wlo[c] = d[4]; m_whi[c] = d[5]; m_rlo[c] = d[4]; m_rhi[c] = d[5];
        m_stage[c] = 0;
      end
    end else if (a == 3'd4) begin
      m_gate = d[0];
      tag = "R11";
    end else if (a < 3) begin
      int c = int'(a);
      if (!m_wlo[c] && !m_whi[c]) tag = "R10";
      else begin
        logic fin;
        fin = m_wlo[c] ^ m_whi[c];
        tag = (m_rw[c] == 2'b11) ? "R3" : "R4";
        if (m_wlo[c]) begin m_stage[c][7:0] = d; m_wlo[c] = 0; end
        else begin m_stage[c][15:8] = d; m_whi[c] = 0; end
        if (fin) begin
          e_load[c] = 1; e_cnt[c] = m_stage[c]; e_mode[c] = m_mode[c]; e_bcd[c] = m_bcd[c];
          m_null[c] = 0; m_cl[c] = 0; m_sl[c] = 0;
        end
      end
    end else tag = "R1";
  endtask

  task automatic m_read(logic [2:0] a, output logic [7:0] v, output string tag);
    v = 8'h00;
    if (a == 3'd3) begin v = 8'hFF; tag = "R1"; end
    else if (a == 3'd4) begin v = {2'b00, ch_out[2], 4'b0000, m_gate}; tag = "R11"; end
    else if (a > 3'd4) tag = "R1";
    else begin
      int c = int'(a);
      logic [15:0] src;
      src = m_cl[c] ? m_cv[c] : live(c);
      tag = m_cl[c] ? "R6" : "R5";
      if (m_sl[c]) begin v = m_sv[c]; m_sl[c] = 0; tag = "R8"; end
      else if (m_rlo[c] || m_rhi[c]) begin
        if (m_rlo[c]) begin v = src[7:0]; m_rlo[c] = 0; end
        else begin v = src[15:8]; m_rhi[c] = 0; end
        if (!m_rlo[c] && !m_rhi[c]) m_cl[c] = 0;
      end
    end
  endtask

  task automatic shuffle();
    ch_count = {$urandom, $urandom} & 48'hFFFF_FFFF_FFFF;
    ch_out = 3'($urandom);
  endtask

  task automatic do_write(logic [2:0] a, logic [7:0] d);
    string tag;
    @(negedge clk);
    shuffle();
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    m_write(a, d, tag);
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    chk(pick(tag), 32'(ch_load), 32'(e_load));
    for (int i = 0; i < 3; i++)
      if (e_load[i])
        chk(pick(tag), {12'd0, ch_load_count[i*16 +: 16], ch_load_mode[i*3 +: 3], ch_load_bcd[i]},
            {12'd0, e_cnt[i], e_mode[i], e_bcd[i]});
    if (a == 3'd4) chk("R11", 32'(gate2), 32'(m_gate));
  endtask

  task automatic do_read(logic [2:0] a);
    string tag;
    logic [7:0] v;
    @(negedge clk);
    shuffle();
    req_valid = 1; req_write = 0; req_addr = a;
    while (!req_ready) @(negedge clk);
    m_read(a, v, tag);
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    chk(pick(tag), {23'd0, rsp_valid, rsp_rdata}, {23'd0, 1'b1, v});
  endtask

  initial begin
    #(20 * 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    m_reset();
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R12 reset ready", 32'(req_ready), 1);
    chk("R12 reset rsp", 32'(rsp_valid), 0);
    chk("R3 reset load", 32'(ch_load), 0);
    chk("R11 reset gate", 32'(gate2), 0);

    // directed corner cases
    do_read(3'd3);                          // R1
    do_read(3'd6);                          // R1 unused
    do_write(3'd3, 8'b00_11_010_1);         // R2 program ch0
    tag_ovr = "R2";
    do_write(3'd3, 8'b1110_0010);           // read-back status ch0 only
    do_read(3'd0);                          // status with null-count set
    tag_ovr = "";
    do_write(3'd0, 8'h34);                  // R3 first byte, no load
    do_write(3'd0, 8'h12);                  // R3 load 0x1234
    do_write(3'd3, 8'b00_00_0000);          // R6 latch ch0
    do_read(3'd0);
    do_write(3'd3, 8'b00_00_0000);          // R6 ignored while unread
    do_read(3'd0);
    do_read(3'd0);                          // R5 nothing left
    tag_ovr = "R7";
    do_write(3'd3, 8'b01_11_011_0);         // program ch1
    do_write(3'd3, 8'b1101_1100);           // read-back count ch1, ch2
    do_read(3'd1);
    do_read(3'd1);
    tag_ovr = "R9";
    do_write(3'd3, 8'b01_00_0000);          // latch ch1
    do_write(3'd3, 8'b1110_0100);           // status latch ch1
    do_write(3'd1, 8'h55);
    do_write(3'd1, 8'hAA);                  // load discards both latches
    do_write(3'd3, 8'b01_11_011_0);
    do_read(3'd1);
    do_read(3'd1);
    tag_ovr = "";
    do_write(3'd0, 8'h77);                  // R10 ignored
    do_write(3'd3, 8'b10_01_000_0);         // ch2 low-only
    do_write(3'd2, 8'hAB);                  // R4 load 0x00AB
    do_write(3'd3, 8'b10_10_001_0);         // ch2 high-only
    do_write(3'd2, 8'hCD);                  // R4 load 0xCD00
    do_write(3'd5, 8'hFF);                  // R1 unused write
    do_write(3'd4, 8'h01);                  // R11 gate high

    // R12 back-pressure
    begin
      logic [7:0] v;
      string tag;
      @(negedge clk);
      rsp_ready = 0;
      req_valid = 1; req_write = 0; req_addr = 3'd4;
      m_read(3'd4, v, tag);
      @(posedge clk);
      @(negedge clk);
      req_valid = 0;
      for (int k = 0; k < 3; k++) begin
        shuffle();
        chk("R12 hold", {22'd0, rsp_valid, req_ready, rsp_rdata}, {22'd0, 1'b1, 1'b0, v});
        @(negedge clk);
      end
      rsp_ready = 1;
      @(negedge clk);
      chk("R12 release", {30'd0, rsp_valid, req_ready}, {30'd0, 1'b0, 1'b1});
    end

    // constrained random traffic
    for (int n = 0; n < 1500; n++) begin
      int r;
      r = $urandom_range(99);
      if (r < 10) begin
        logic [1:0] c; logic [1:0] am;
        c = 2'($urandom_range(2)); am = 2'($urandom_range(3, 1));
        do_write(3'd3, {c, am, 3'($urandom), 1'($urandom)});
      end else if (r < 16) begin
        do_write(3'd3, {2'($urandom_range(2)), 6'b00_0000});
      end else if (r < 24) begin
        do_write(3'd3, {2'b11, 5'($urandom), 1'b0});
      end else if (r < 48) begin
        do_write(3'($urandom_range(2)), 8'($urandom));
      end else if (r < 85) begin
        do_read(3'($urandom_range(2)));
      end else if (r < 92) begin
        do_read(3'($urandom_range(7, 3)));
      end else begin
        do_write(3'($urandom_range(7, 4)), 8'($urandom));
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule